// File: doc/BRIEF.md
# Fractional-N Divide-Ratio Sequencer with Pulse-Swallow Divider

This block sets the feedback division of a fractional-N frequency synthesizer. A programmable integer ratio and a 19-bit fraction are combined with a signed trim code into one fixed-point word. A second-order, single-loop error-feedback sigma-delta modulator turns the fractional part into a per-cycle offset of -1, 0, +1 or +2. That offset is added to the integer part to give the ratio for the next divided cycle. Over time, the average ratio equals the programmed word.

The ratio is split into a program count P (ratio divided by 8) and a swallow count S (ratio modulo 8). These drive an 8/9 dual-modulus prescaler model followed by program and swallow counters. The clock input is the oscillator-rate clock. Each divided cycle therefore lasts 9S + 8(P - S) = ratio clock cycles. The modulator advances once per divided cycle, at the divider's terminal count.

A baseband controller loads integer and fraction together with `cfg_load`. It writes the carrier-offset trim with `adj_wr`, typically during a packet preamble. Both writes are staged. They reach the divider only at the next divided-cycle boundary.

Top module: `fracn_divctl`

## Requirements
- R1: After reset the staged word is integer 200 with fraction 65536 (1/8), the trim is 0, and `ratio_now` is 200. The first divided cycle lasts exactly 200 clocks, with `div_pulse` and `mod_sel` low during reset.
- R2: Every divided cycle lasts exactly `ratio_now` clocks. `div_pulse` is high only on the last clock of the cycle, so two pulses are never adjacent.
- R3: Within a divided cycle, `mod_sel` is high for the first 9·S clocks and low afterwards, where S = `ratio_now` mod 8 and P = `ratio_now` div 8. S never exceeds P for any integer setting from 57 to 2^INT_W - 3.
- R4: Each new ratio equals the effective integer plus an offset in {-1, 0, +1, +2}. When the effective fraction is 0 from reset, every ratio equals the effective integer exactly.
- R5: Let the effective word be T = integer·2^19 + fraction + trim, and load the configuration before the first boundary after reset. Then, for any count K of following divided cycles, the sum of their lengths times 2^19 differs from K·T by less than 2^19.
- R6: `cfg_load` captures `cfg_int` and `cfg_frac` together. The divided cycle in progress keeps its length, and the new setting governs from the next boundary on.
- R7: `adj_code` is a signed code added to the combined integer-and-fraction word, with borrow and carry into the integer part. It holds until rewritten, including across later `cfg_load` writes, and takes effect from the next boundary.
- R8: `ratio_now` changes only on the clock edge that ends a divided cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock counted by the divider |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Stage `cfg_int` and `cfg_frac` together |
| cfg_int | input | INT_W (8) | Integer part of the division ratio |
| cfg_frac | input | FRAC_W (19) | Fractional part, in units of 2^-19 |
| adj_wr | input | 1 | Stage `adj_code` |
| adj_code | input | ADJ_W (18) | Signed trim in fraction units |
| div_pulse | output | 1 | High on the last clock of each divided cycle |
| mod_sel | output | 1 | Prescaler modulus select: high for divide-by-9 |
| ratio_now | output | INT_W (8) | Ratio of the divided cycle in progress |

## Verification
The bound checker watches four behaviours on every clock:
- the ratio holds steady between boundaries;
- no two boundary pulses are adjacent;
- divide-by-9 operation starts only at a boundary;
- the swallow count never exceeds the program count.

Other properties span many divided cycles, or depend on when a write lands, so only the bench's scenarios can show them. These include the exact cycle length, the ratio offset range, and the long-run average accuracy. They also include the carry and borrow of the trim and the persistence of staged writes across the boundary.

// File: rtl/fracn_divctl.sv
module fracn_divctl #(
  parameter int FRAC_W   = 19,
  parameter int INT_W    = 8,
  parameter int ADJ_W    = 18,
  parameter int DEF_INT  = 200,
  parameter int DEF_FRAC = 65536
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [INT_W-1:0]  cfg_int,
  input  logic [FRAC_W-1:0] cfg_frac,
  input  logic              adj_wr,
  input  logic [ADJ_W-1:0]  adj_code,
  output logic              div_pulse,
  output logic              mod_sel,
  output logic [INT_W-1:0]  ratio_now
);
  localparam int WORD_W = INT_W + FRAC_W;
  localparam int V_W    = FRAC_W + 3;
  localparam int P_W    = INT_W - 3;

  logic [INT_W-1:0]  stg_int;
  logic [FRAC_W-1:0] stg_frac;
  logic [ADJ_W-1:0]  stg_adj;
  logic [WORD_W-1:0] adj_ext, eff_word;
  logic [INT_W-1:0]  eff_int, n_next, n_cur;
  logic [FRAC_W-1:0] eff_frac, err1, err2, err_new;
  logic [V_W-1:0]    acc;
  logic [2:0]        step;
  logic [3:0]        pre_cnt;
  logic [P_W-1:0]    prog_cnt, p_cur;
  logic [2:0]        swl_left;
  logic              pre_end;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stg_int  <= INT_W'(DEF_INT);
      stg_frac <= FRAC_W'(DEF_FRAC);
      stg_adj  <= '0;
    end else begin
      if (cfg_load) begin
        stg_int  <= cfg_int;
        stg_frac <= cfg_frac;
      end
      if (adj_wr) stg_adj <= adj_code;
    end

  assign adj_ext  = {{(WORD_W-ADJ_W){stg_adj[ADJ_W-1]}}, stg_adj};
  assign eff_word = {stg_int, stg_frac} + adj_ext;
  assign eff_int  = eff_word[WORD_W-1:FRAC_W];
  assign eff_frac = eff_word[FRAC_W-1:0];

  assign acc     = {3'b000, eff_frac} + {2'b00, err1, 1'b0} - {3'b000, err2};
  assign step    = acc[V_W-1:FRAC_W];
  assign err_new = acc[FRAC_W-1:0];
  assign n_next  = eff_int + {{(INT_W-3){step[2]}}, step};

  assign p_cur     = n_cur[INT_W-1:3];
  assign mod_sel   = |swl_left;
  assign pre_end   = pre_cnt == (mod_sel ? 4'd8 : 4'd7);
  assign div_pulse = pre_end && (prog_cnt == p_cur - P_W'(1));
  assign ratio_now = n_cur;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      n_cur    <= INT_W'(DEF_INT);
      err1     <= '0;
      err2     <= '0;
      pre_cnt  <= '0;
      prog_cnt <= '0;
      swl_left <= 3'(DEF_INT % 8);
    end else if (div_pulse) begin
      n_cur    <= n_next;
      err1     <= err_new;
      err2     <= err1;
      pre_cnt  <= '0;
      prog_cnt <= '0;
      swl_left <= n_next[2:0];
    end else if (pre_end) begin
      pre_cnt  <= '0;
      prog_cnt <= prog_cnt + P_W'(1);
      if (mod_sel) swl_left <= swl_left - 3'd1;
    end else begin
      pre_cnt  <= pre_cnt + 4'd1;
    end
endmodule

// File: rtl/fracn_divctl_chk.sv
module fracn_divctl_chk #(
  parameter int INT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             div_pulse,
  input logic             mod_sel,
  input logic [INT_W-1:0] ratio_now
);
  // R8
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !div_pulse |=> $stable(ratio_now));

  // R2
  pulse_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  // R3
  swallow_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_sel) |-> $past(div_pulse));

  // R3
  swallow_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_now[2:0] <= ratio_now[INT_W-1:3]);
endmodule

bind fracn_divctl fracn_divctl_chk #(.INT_W(INT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .div_pulse(div_pulse),
  .mod_sel(mod_sel), .ratio_now(ratio_now));

// File: tb/test_fracn_divctl.sv
`timescale 1ns/1ps
module test_fracn_divctl;
  localparam longint Q = 524288;
  localparam int NV = 8;
  localparam int V_INT  [NV] = '{60, 60, 64, 90, 75, 57, 253, 100};
  localparam int V_FRAC [NV] = '{0, 262144, 65536, 1, 0, 500000, 400000, 524287};
  localparam int V_ADJ  [NV] = '{0, 0, 0, 0, -100000, 0, 0, 1};
  localparam int V_K    [NV] = '{150, 200, 200, 100, 150, 150, 60, 80};

  logic clk = 0, rst_n = 0, cfg_load = 0, adj_wr = 0;
  logic [7:0]  cfg_int = 0;
  logic [18:0] cfg_frac = 0;
  logic [17:0] adj_code = 0;
  logic div_pulse, mod_sel;
  logic [7:0] ratio_now;

  int checks = 0, errors = 0;
  int len_acc = 0, hi_acc = 0, last_len = 0, periods = 0;
  bit done = 0;

  fracn_divctl i_fracn_divctl (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_int(cfg_int),
    .cfg_frac(cfg_frac), .adj_wr(adj_wr), .adj_code(adj_code),
    .div_pulse(div_pulse), .mod_sel(mod_sel), .ratio_now(ratio_now));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk)
    if (!rst_n) begin
      len_acc = 0;
      hi_acc = 0;
    end else begin
      len_acc++;
      hi_acc += int'(mod_sel);
      if (div_pulse) begin
        chk(len_acc == int'(ratio_now), "R2", len_acc, ratio_now);
        chk(hi_acc == 9 * (len_acc % 8), "R3", hi_acc, 9 * (len_acc % 8));
        last_len = len_acc;
        periods++;
        len_acc = 0;
        hi_acc = 0;
      end
    end

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
  endtask

  task automatic next_len(output int l);
    int p = periods;
    wait (periods == p + 1);
    l = last_len;
  endtask

  task automatic write_cfg(input bit ld, input int ival, input int fval, input bit aw, input int aval);
    @(negedge clk);
    cfg_load = ld; cfg_int = 8'(ival); cfg_frac = 19'(fval);
    adj_wr = aw; adj_code = 18'(aval);
    @(negedge clk);
    cfg_load = 0; adj_wr = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #4000000;
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int l;
    longint sum, t, ie, fe, diff;

    do_reset();
    #1;
    chk(ratio_now == 8'd200, "R1", ratio_now, 200);
    chk(div_pulse == 0, "R1", div_pulse, 0);
    chk(mod_sel == 0, "R1", mod_sel, 0);
    next_len(l);
    chk(l == 200, "R1", l, 200);
    sum = 0;
    for (int k = 0; k < 200; k++) begin
      next_len(l);
      chk(l >= 199 && l <= 202, "R4", l, 200);
      sum += l;
    end
    diff = sum * Q - 200 * (200 * Q + 65536);
    chk(diff > -Q && diff < Q, "R1 R5", diff, 0);

    for (int v = 0; v < NV; v++) begin
      do_reset();
      write_cfg(1, V_INT[v], V_FRAC[v], 1, V_ADJ[v]);
      next_len(l);
      chk(l == 200, "R1", l, 200);
      t = longint'(V_INT[v]) * Q + V_FRAC[v] + V_ADJ[v];
      ie = t / Q;
      fe = t % Q;
      sum = 0;
      for (int k = 0; k < V_K[v]; k++) begin
        next_len(l);
        chk(l >= ie - 1 && l <= ie + 2, "R4", l, ie);
        if (fe == 0) chk(l == ie, "R4 R7", l, ie);
        sum += l;
      end
      diff = sum * Q - longint'(V_K[v]) * t;
      chk(diff > -Q && diff < Q, "R5", diff, 0);
    end

    do_reset();
    write_cfg(1, 100, 0, 0, 0);
    next_len(l);
    next_len(l);
    chk(l == 100, "R4", l, 100);
    repeat (30) @(negedge clk);
    cfg_load = 1; cfg_int = 8'd80; cfg_frac = '0;
    @(negedge clk);
    cfg_load = 0;
    next_len(l);
    chk(l == 100, "R6", l, 100);
    next_len(l);
    chk(l == 80, "R6", l, 80);

    do_reset();
    write_cfg(1, 100, 524287, 1, 1);
    next_len(l);
    next_len(l);
    chk(l == 101, "R7", l, 101);
    repeat (25) @(negedge clk);
    cfg_load = 1; cfg_int = 8'd70; cfg_frac = 19'd524287;
    @(negedge clk);
    cfg_load = 0;
    next_len(l);
    chk(l == 101, "R6", l, 101);
    next_len(l);
    chk(l == 71, "R7", l, 71);
    repeat (25) @(negedge clk);
    adj_wr = 1; adj_code = '0;
    @(negedge clk);
    adj_wr = 0;
    next_len(l);
    chk(l == 71, "R7", l, 71);
    next_len(l);
    chk(l >= 69 && l <= 72, "R7", l, 70);

    finish_run();
  end
endmodule